// File: doc/BRIEF.md
# GPIO Output and Input Register Block

This block is the register file that drives a 32-pin general-purpose I/O unit. It keeps two internal words: the value each pin drives when it is an output, and the tri-state enable for each pin. Software can replace a whole word in one write. It can also change only some bits of one 16-bit half, selected by a mask carried in the same write. A pin whose enable bit is 0 is an input.

Both internal words appear directly on the pin outputs. Every view of a word reads back the merged result of all earlier writes. The block also passes the pins through a two-stage synchronizer into a readable input register. Access is through a plain single-cycle port: a word address, write data, a write strobe and combinational read data.

Word address map: 0 input value (read only), 1 output data, 2 output data lower half masked, 3 output data upper half masked, 4 output enable, 5 output enable lower half masked, 6 output enable upper half masked. Address 7 is unused.

Top module: `gpio_out_regs`

## Requirements
- R1: While reset is asserted, and after it is released with no writes made, `pin_o` and `pin_oe_o` are all zeros and known. Every read view of the two words returns 0.
- R2: A write to address 1 replaces all 32 bits of the output-data word with `wdata_i`. The new value is on `pin_o` and reads back at address 1 after the clock edge that accepts the write.
- R3: A write to address 4 replaces all 32 bits of the output-enable word. The new value is on `pin_oe_o` and reads back at address 4 after the accepting edge.
- R4: A write to address 2 uses `wdata_i[31:16]` as a mask and `wdata_i[15:0]` as data. For each i in 0..15, output-data bit i takes data bit i where mask bit i is 1 and keeps its value where it is 0. Bits 31:16 of the word do not change.
- R5: A write to address 3 applies the same mask/data layout to output-data bits 31:16, where mask bit i and data bit i act on word bit 16+i. Bits 15:0 do not change.
- R6: Writes to address 5 (lower half) and address 6 (upper half) apply the masked update of R4 and R5 to the output-enable word.
- R7: A read at address 2 or 5 returns zeros in bits 31:16 and the lower half of the matching word in bits 15:0. A read at address 3 or 6 returns zeros in bits 31:16 and the upper half of the matching word in bits 15:0.
- R8: A read at address 0 returns `pin_i` as it was sampled two clock edges earlier. After only one edge, the read still shows the value from before the change.
- R9: Writes to address 0 or 7 change neither word, and a read at address 7 returns 0. With no write strobe, both words hold their value.
- R10: Writes through the output-data views never change the output-enable word, and writes through the enable views never change the output-data word. After any mix of writes, every view of a word reflects the merged result of all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Word address for read and write |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe; the write is taken at the rising edge |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pin_i | input | 32 | Pin values seen at the pads |
| pin_o | output | 32 | Output-data word driven to the pins |
| pin_oe_o | output | 32 | Output-enable word, 1 drives the pin |

## Verification
A write strobed at one rising edge shows on `pin_o`, `pin_oe_o` and every read view one edge later. The bench drives each write in the half cycle before that edge and compares in the half cycle after it, against a model that applies the mask merge arithmetically. A pin change needs two edges to reach the input view, so the bench changes `pin_i` at a falling edge, expects the old value after one edge and the new value after two. A long pseudo-random sweep of addresses and data follows the directed cases, and after every write the bench compares both pin words and all eight read addresses.

// File: rtl/gpio_out_pkg.sv
package gpio_out_pkg;
  localparam int unsigned NUM_PINS = 32;
  localparam int unsigned HALF_W   = NUM_PINS / 2;
  localparam int unsigned ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIN     = 3'd0,
    REG_DOUT    = 3'd1,
    REG_MOUT_LO = 3'd2,
    REG_MOUT_HI = 3'd3,
    REG_DOE     = 3'd4,
    REG_MOE_LO  = 3'd5,
    REG_MOE_HI  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else begin
        if (s == 0) stage_q[s] <= d_i;
        else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

  AST_SYNC_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(d_i) |=> !$isunknown(stage_q[0])) else $error("sync stage unknown"); // R8
endmodule

// File: rtl/gpio_word_reg.sv
module gpio_word_reg #(
  parameter int unsigned W = 32,
  localparam int unsigned H = W / 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_full_i,
  input  logic         we_lo_i,
  input  logic         we_hi_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [H-1:0] half_q [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic         sel;
    logic [H-1:0] mask;
    logic [H-1:0] data;

    // full write: all-ones mask, data taken from its own half
    assign sel  = we_full_i | ((h == 0) ? we_lo_i : we_hi_i);
    assign mask = we_full_i ? {H{1'b1}} : wdata_i[W-1:H];
    assign data = we_full_i ? wdata_i[h*H +: H] : wdata_i[H-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  half_q[h] <= '0;
      else if (sel) half_q[h] <= (half_q[h] & ~mask) | (data & mask);
    end

    assign q_o[h*H +: H] = half_q[h];
  end

  AST_FULL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_full_i |=> q_o == $past(wdata_i)) else $error("full load"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_full_i || we_lo_i || we_hi_i) |=> $stable(q_o)) else $error("idle hold"); // R9
  AST_LO_KEEPS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_lo_i && !we_full_i && !we_hi_i) |=> $stable(q_o[W-1:H])) else $error("lo keeps hi"); // R4
  AST_LO_UNMASKED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_lo_i && !we_full_i) |=>
      ((q_o[H-1:0] ^ $past(q_o[H-1:0])) & ~$past(wdata_i[W-1:H])) == '0) else $error("lo mask"); // R4
  AST_HI_KEEPS_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_hi_i && !we_full_i && !we_lo_i) |=> $stable(q_o[H-1:0])) else $error("hi keeps lo"); // R5
  AST_HI_UNMASKED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_hi_i && !we_full_i) |=>
      ((q_o[W-1:H] ^ $past(q_o[W-1:H])) & ~$past(wdata_i[W-1:H])) == '0) else $error("hi mask"); // R5
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_out_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic                we_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [NUM_PINS-1:0] out_q, oe_q, din_q;
  logic we_dout, we_mout_lo, we_mout_hi, we_doe, we_moe_lo, we_moe_hi;

  assign we_dout    = we_i && (addr_i == REG_DOUT);
  assign we_mout_lo = we_i && (addr_i == REG_MOUT_LO);
  assign we_mout_hi = we_i && (addr_i == REG_MOUT_HI);
  assign we_doe     = we_i && (addr_i == REG_DOE);
  assign we_moe_lo  = we_i && (addr_i == REG_MOE_LO);
  assign we_moe_hi  = we_i && (addr_i == REG_MOE_HI);

  gpio_word_reg #(.W(NUM_PINS)) u_out_word (
    .clk_i, .rst_ni,
    .we_full_i (we_dout),
    .we_lo_i   (we_mout_lo),
    .we_hi_i   (we_mout_hi),
    .wdata_i,
    .q_o       (out_q)
  );

  gpio_word_reg #(.W(NUM_PINS)) u_oe_word (
    .clk_i, .rst_ni,
    .we_full_i (we_doe),
    .we_lo_i   (we_moe_lo),
    .we_hi_i   (we_moe_hi),
    .wdata_i,
    .q_o       (oe_q)
  );

  gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk_i, .rst_ni,
    .d_i (pin_i),
    .q_o (din_q)
  );

  always_comb begin
    unique case (addr_i)
      REG_DIN:     rdata_o = din_q;
      REG_DOUT:    rdata_o = out_q;
      REG_MOUT_LO: rdata_o = {{HALF_W{1'b0}}, out_q[HALF_W-1:0]};
      REG_MOUT_HI: rdata_o = {{HALF_W{1'b0}}, out_q[NUM_PINS-1:HALF_W]};
      REG_DOE:     rdata_o = oe_q;
      REG_MOE_LO:  rdata_o = {{HALF_W{1'b0}}, oe_q[HALF_W-1:0]};
      REG_MOE_HI:  rdata_o = {{HALF_W{1'b0}}, oe_q[NUM_PINS-1:HALF_W]};
      default:     rdata_o = '0;
    endcase
  end

  assign pin_o    = out_q;
  assign pin_oe_o = oe_q;

  AST_PINS_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({pin_o, pin_oe_o})) else $error("pins unknown"); // R1
  AST_OUT_VIEWS_KEEP_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i inside {REG_DOUT, REG_MOUT_LO, REG_MOUT_HI})) |=> $stable(pin_oe_o))
    else $error("oe disturbed"); // R10
  AST_OE_VIEWS_KEEP_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i inside {REG_DOE, REG_MOE_LO, REG_MOE_HI})) |=> $stable(pin_o))
    else $error("out disturbed"); // R10
  AST_NOREG_WRITE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i inside {REG_DIN, 3'd7})) |=> ($stable(pin_o) && $stable(pin_oe_o)))
    else $error("unmapped write"); // R9
endmodule

// File: tb/gpio_out_regs_tb.sv
module gpio_out_regs_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W = 32;
  localparam int unsigned H = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   addr_i = '0;
  logic [W-1:0] wdata_i = '0;
  logic         we_i = 1'b0;
  logic [W-1:0] rdata_o, pin_i, pin_o, pin_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] m_out = '0, m_oe = '0, m_din = '0;
  logic [31:0]  seed = 32'h1bad_c0de;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_out_regs u_dut (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .rdata_o,
    .pin_i, .pin_o, .pin_oe_o
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] merge(input logic [W-1:0] cur, input logic [W-1:0] wd, input bit hi);
    logic [H-1:0] msk, dat, old, nw;
    msk = wd[W-1:H];
    dat = wd[H-1:0];
    old = hi ? cur[W-1:H] : cur[H-1:0];
    nw  = (old & ~msk) | (dat & msk);
    return hi ? {nw, cur[H-1:0]} : {cur[W-1:H], nw};
  endfunction

  function automatic logic [W-1:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_din;
      3'd1: return m_out;
      3'd2: return {16'h0, m_out[H-1:0]};
      3'd3: return {16'h0, m_out[W-1:H]};
      3'd4: return m_oe;
      3'd5: return {16'h0, m_oe[H-1:0]};
      3'd6: return {16'h0, m_oe[W-1:H]};
      default: return '0;
    endcase
  endfunction

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    case (a)
      3'd1: m_out = d;
      3'd2: m_out = merge(m_out, d, 1'b0);
      3'd3: m_out = merge(m_out, d, 1'b1);
      3'd4: m_oe  = d;
      3'd5: m_oe  = merge(m_oe, d, 1'b0);
      3'd6: m_oe  = merge(m_oe, d, 1'b1);
      default: ;
    endcase
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [W-1:0] exp);
    addr_i = a;
    #1;
    check(tag, rdata_o, exp);
  endtask

  task automatic check_all(input string tag);
    check({tag, " pin_o"}, pin_o, m_out);
    check({tag, " pin_oe_o"}, pin_oe_o, m_oe);
    for (int a = 0; a < 8; a++) rd($sformatf("%s R7 view%0d", tag, a), 3'(a), exp_read(3'(a)));
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pin_i = 32'h0;
    repeat (3) @(negedge clk_i);
    check("R1 pin_o in reset", pin_o, '0);
    check("R1 pin_oe_o in reset", pin_oe_o, '0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check_all("R1 after reset");

    wr(3'd1, 32'ha5a5_0f0f);  check_all("R2 direct out");
    wr(3'd4, 32'hffff_0000);  check_all("R3 direct oe");
    wr(3'd2, 32'h00ff_1234);  check_all("R4 masked out lo");
    check("R4 value", pin_o, 32'ha5a5_0f34);
    wr(3'd3, 32'hf000_ffff);  check_all("R5 masked out hi");
    check("R5 value", pin_o, 32'hf5a5_0f34);
    wr(3'd5, 32'h8001_ffff);  check_all("R6 masked oe lo");
    check("R6 lo value", pin_oe_o, 32'hffff_8001);
    wr(3'd6, 32'h0f0f_0000);  check_all("R6 masked oe hi");
    check("R6 hi value", pin_oe_o, 32'hf0f0_8001);
    wr(3'd2, 32'h0000_ffff);  check_all("R4 zero mask");
    wr(3'd0, 32'hdead_beef);  check_all("R9 write din");
    wr(3'd7, 32'hdead_beef);  check_all("R9 write unused");

    // input synchronizer latency
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] v;
      seed = next_rand(seed);
      v = seed;
      @(negedge clk_i);
      pin_i = v;
      @(negedge clk_i);
      rd("R8 one edge", 3'd0, m_din);
      @(negedge clk_i);
      m_din = v;
      rd("R8 two edges", 3'd0, m_din);
    end

    // mixed sweep over all addresses and random data
    for (int i = 0; i < 1500; i++) begin
      logic [2:0] a;
      seed = next_rand(seed);
      a = seed[2:0];
      seed = next_rand(seed);
      if (i % 5 == 0) seed[31:16] = (i % 10 == 0) ? 16'h0000 : 16'hffff;
      wr(a, seed);
      check_all("R10 sweep");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule